// File: doc/BRIEF.md
# Exposure and Gain Frame Shadow

This block stages exposure (coarse integration time) and gain settings for a rolling-shutter image sensor so that register writes from a host never land in the middle of a frame. A host writes an exposure value, a broadcast gain or any of four per-color gains through a simple write port. Every write is first captured in a pending register. Pending values only reach the live outputs when a new frame starts, which is the rising edge of the frame-valid input.

If exposure and gain change in the same frame, the gain is held back by one extra frame. A new exposure shows up on the output two frames after it was written, so this delay makes the new gain appear on that same output frame. A gain change on its own moves to live at the next frame start. A broadcast gain write updates all four color lanes at once.

The block also counts frame starts. It reports, as a tag, the index of the first output frame that was integrated with the current live exposure.

Top module: `expgain_shadow`

## Requirements
- R1: A write with select code 0 stores `wr_data` as the pending exposure. `live_exp` keeps its value until the next frame start.
- R2: A frame start is a cycle in which `frame_valid` is 1 after being 0 in the previous cycle. Live outputs change only in the cycle after a frame start. Holding `frame_valid` high does not cause a second start.
- R3: `frame_idx` increases by one at every frame start. When a pending exposure moves to live, `exp_tag` becomes the index before that start plus 2, which is the first output frame integrated with the new exposure.
- R4: If a new exposure is written in each of several consecutive frames, each value is live for exactly one frame.
- R5: A gain write in a frame with no pending exposure reaches `live_gain` at the next frame start.
- R6: If exposure and gain are both pending at a frame start, the exposure moves to live at once. The gain moves to live at the following frame start.
- R7: A write with select code 1 (broadcast) writes the low 3 bits of `wr_data` into all four color lanes. Lane c sits at `live_gain[3c+2:3c]`.
- R8: A write with select code 4+c writes lane c only. Within one frame, the most recent write to a lane wins, whether it was a broadcast write or a lane write.
- R9: A frame start with no pending write leaves all live values unchanged.
- R10: Writes with select codes 2 and 3 have no effect.
- R11: A write in the same cycle as a frame start belongs to the new frame. It reaches live at the start after that.
- R12: After reset, `live_exp` is 0, every gain lane is 1, and `frame_idx` and `exp_tag` are 0.
- R13: A gain-only write made while a held gain is waiting replaces the held value for that lane at the next start. Other held lanes still take their held values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | Frame-valid level; its rising edge marks a frame start |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target: 0 exposure, 1 broadcast gain, 4..7 color lane 0..3 |
| wr_data | input | 16 | Write data; gains use the low 3 bits |
| live_exp | output | 16 | Live integration time |
| live_gain | output | 12 | Four live 3-bit gains, lane c at bits [3c+2:3c] |
| frame_idx | output | 8 | Count of frame starts since reset |
| exp_tag | output | 8 | First output frame integrated with the live exposure |

## Verification
The stimulus tries the transfer rules with several patterns:
- exposure alone
- gain alone
- both changed together
- a new exposure on back-to-back frames
- broadcast and lane writes mixed in both orders
- a lane write landing while a held gain waits

Comparing a gain-only frame against a combined frame shows whether the holdoff is applied only when it should be. Reversing the broadcast/lane order shows whether the latest write wins per lane.

Two further cases test the frame-start rules. Starts with nothing pending and writes to unused codes must leave the outputs alone. A write placed exactly on the start cycle checks which frame that write belongs to.

// File: rtl/expgain_pkg.sv
package expgain_pkg;
  localparam int NCOLOR = 4;
  localparam int SEL_W  = 3;
  localparam logic [SEL_W-1:0] SEL_EXP        = 3'd0;
  localparam logic [SEL_W-1:0] SEL_BROADCAST  = 3'd1;
  localparam int               SEL_COLOR_BASE = 4;
endpackage

// File: rtl/expgain_frame_edge.sv
module expgain_frame_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_valid,
  output logic frame_start
);
  logic fv_q;
  logic fv_d;

  always_comb fv_d = frame_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fv_q <= 1'b0;
    else        fv_q <= fv_d;
  end

  assign frame_start = frame_valid & ~fv_q;
endmodule

// File: rtl/expgain_exp_stage.sv
module expgain_exp_stage #(
  parameter int EXP_W   = 16,
  parameter int TAG_W   = 8,
  parameter int RST_EXP = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             exp_wr,
  input  logic [EXP_W-1:0] wr_data,
  input  logic [TAG_W-1:0] frame_idx,
  output logic [EXP_W-1:0] live_exp,
  output logic [TAG_W-1:0] exp_tag,
  output logic             exp_pend
);
  logic [EXP_W-1:0] pend_q, pend_d, live_q, live_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             vld_q, vld_d;

  always_comb begin
    pend_d = pend_q;
    vld_d  = vld_q;
    live_d = live_q;
    tag_d  = tag_q;
    if (frame_start && vld_q) begin
      live_d = pend_q;
      tag_d  = frame_idx + TAG_W'(2);
      vld_d  = 1'b0;
    end
    if (exp_wr) begin
      pend_d = wr_data;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      vld_q  <= 1'b0;
      live_q <= EXP_W'(RST_EXP);
      tag_q  <= '0;
    end else begin
      pend_q <= pend_d;
      vld_q  <= vld_d;
      live_q <= live_d;
      tag_q  <= tag_d;
    end
  end

  assign live_exp = live_q;
  assign exp_tag  = tag_q;
  assign exp_pend = vld_q;
endmodule

// File: rtl/expgain_gain_lane.sv
module expgain_gain_lane #(
  parameter int GAIN_W   = 3,
  parameter int RST_GAIN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              exp_pend,
  input  logic              wr_hit,
  input  logic [GAIN_W-1:0] wr_val,
  output logic [GAIN_W-1:0] live_gain,
  output logic              dly_vld
);
  logic [GAIN_W-1:0] pend_q, pend_d, dly_q, dly_d, live_q, live_d;
  logic              pvld_q, pvld_d, dvld_q, dvld_d;

  always_comb begin
    pend_d = pend_q;
    pvld_d = pvld_q;
    dly_d  = dly_q;
    dvld_d = dvld_q;
    live_d = live_q;
    if (frame_start) begin
      if (dvld_q) begin
        live_d = dly_q;
        dvld_d = 1'b0;
      end
      if (pvld_q) begin
        pvld_d = 1'b0;
        if (exp_pend) begin
          dly_d  = pend_q;
          dvld_d = 1'b1;
        end else begin
          live_d = pend_q;
        end
      end
    end
    if (wr_hit) begin
      pend_d = wr_val;
      pvld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pvld_q <= 1'b0;
      dly_q  <= '0;
      dvld_q <= 1'b0;
      live_q <= GAIN_W'(RST_GAIN);
    end else begin
      pend_q <= pend_d;
      pvld_q <= pvld_d;
      dly_q  <= dly_d;
      dvld_q <= dvld_d;
      live_q <= live_d;
    end
  end

  assign live_gain = live_q;
  assign dly_vld   = dvld_q;
endmodule

// File: rtl/expgain_shadow.sv
module expgain_shadow
  import expgain_pkg::*;
#(
  parameter int EXP_W    = 16,
  parameter int GAIN_W   = 3,
  parameter int TAG_W    = 8,
  parameter int RST_EXP  = 0,
  parameter int RST_GAIN = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_valid,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [EXP_W-1:0]         wr_data,
  output logic [EXP_W-1:0]         live_exp,
  output logic [NCOLOR*GAIN_W-1:0] live_gain,
  output logic [TAG_W-1:0]         frame_idx,
  output logic [TAG_W-1:0]         exp_tag
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              frame_start;
  logic              exp_wr, bcast_wr, exp_pend;
  logic [NCOLOR-1:0] lane_hit, gain_dly_vld;
  logic [TAG_W-1:0]  idx_q, idx_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  expgain_frame_edge u_edge (
    .clk(clk), .rst_n(rst_sync_n), .frame_valid(frame_valid), .frame_start(frame_start)
  );

  assign exp_wr   = wr_en && (wr_sel == SEL_EXP);
  assign bcast_wr = wr_en && (wr_sel == SEL_BROADCAST);

  always_comb idx_d = frame_start ? idx_q + TAG_W'(1) : idx_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) idx_q <= '0;
    else             idx_q <= idx_d;
  end
  assign frame_idx = idx_q;

  expgain_exp_stage #(.EXP_W(EXP_W), .TAG_W(TAG_W), .RST_EXP(RST_EXP)) u_exp (
    .clk(clk), .rst_n(rst_sync_n), .frame_start(frame_start), .exp_wr(exp_wr),
    .wr_data(wr_data), .frame_idx(idx_q), .live_exp(live_exp), .exp_tag(exp_tag),
    .exp_pend(exp_pend)
  );

  for (genvar c = 0; c < NCOLOR; c++) begin : g_lane
    assign lane_hit[c] = bcast_wr || (wr_en && (wr_sel == SEL_W'(SEL_COLOR_BASE + c)));
    expgain_gain_lane #(.GAIN_W(GAIN_W), .RST_GAIN(RST_GAIN)) u_lane (
      .clk(clk), .rst_n(rst_sync_n), .frame_start(frame_start), .exp_pend(exp_pend),
      .wr_hit(lane_hit[c]), .wr_val(wr_data[GAIN_W-1:0]),
      .live_gain(live_gain[c*GAIN_W +: GAIN_W]), .dly_vld(gain_dly_vld[c])
    );
  end
endmodule

// File: rtl/expgain_shadow_chk.sv
module expgain_shadow_chk #(
  parameter int EXP_W  = 16,
  parameter int GW_ALL = 12,
  parameter int TAG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fs,
  input logic              exp_pend,
  input logic              dly_any,
  input logic [EXP_W-1:0]  live_exp,
  input logic [GW_ALL-1:0] live_gain,
  input logic [TAG_W-1:0]  frame_idx,
  input logic [TAG_W-1:0]  exp_tag
);
  AST_LIVE_ONLY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !fs |=> ($stable(live_exp) && $stable(live_gain))); // R2
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fs |=> frame_idx == TAG_W'($past(frame_idx) + TAG_W'(1))); // R3
  AST_TAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fs && exp_pend) |=> exp_tag == TAG_W'($past(frame_idx) + TAG_W'(2))); // R3
  AST_GAIN_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (fs && exp_pend && !dly_any) |=> $stable(live_gain)); // R6
  AST_EXP_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (fs && !exp_pend) |=> $stable(live_exp)); // R9
endmodule

bind expgain_shadow expgain_shadow_chk #(
  .EXP_W(EXP_W), .GW_ALL(expgain_pkg::NCOLOR*GAIN_W), .TAG_W(TAG_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .fs(frame_start), .exp_pend(exp_pend),
  .dly_any(|gain_dly_vld), .live_exp(live_exp), .live_gain(live_gain),
  .frame_idx(frame_idx), .exp_tag(exp_tag)
);

// File: tb/expgain_shadow_tb_top.sv
module expgain_shadow_tb_top;
  localparam time TCK = 20ns;
  localparam int  NV  = 31;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_valid = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] live_exp;
  logic [11:0] live_gain;
  logic [7:0]  frame_idx, exp_tag;

  int n_chk = 0;
  int n_fail = 0;

  always #(TCK/2) clk = ~clk;

  expgain_shadow dut_i (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .live_exp(live_exp), .live_gain(live_gain),
    .frame_idx(frame_idx), .exp_tag(exp_tag)
  );

  // {op(1: frame start, 0: write), sel, data, expected exposure, expected gains {c3,c2,c1,c0}}
  localparam logic [47:0] VEC [NV] = '{
    {1'b0, 3'd0, 16'd100, 16'd0,   3'd1, 3'd1, 3'd1, 3'd1}, // R1
    {1'b1, 3'd0, 16'd0,   16'd100, 3'd1, 3'd1, 3'd1, 3'd1}, // R1
    {1'b1, 3'd0, 16'd0,   16'd100, 3'd1, 3'd1, 3'd1, 3'd1}, // R9
    {1'b0, 3'd1, 16'd5,   16'd100, 3'd1, 3'd1, 3'd1, 3'd1},
    {1'b1, 3'd0, 16'd0,   16'd100, 3'd5, 3'd5, 3'd5, 3'd5}, // R5 R7
    {1'b0, 3'd1, 16'd2,   16'd100, 3'd5, 3'd5, 3'd5, 3'd5},
    {1'b0, 3'd6, 16'd7,   16'd100, 3'd5, 3'd5, 3'd5, 3'd5},
    {1'b1, 3'd0, 16'd0,   16'd100, 3'd2, 3'd7, 3'd2, 3'd2}, // R8
    {1'b0, 3'd5, 16'd4,   16'd100, 3'd2, 3'd7, 3'd2, 3'd2},
    {1'b0, 3'd1, 16'd3,   16'd100, 3'd2, 3'd7, 3'd2, 3'd2},
    {1'b1, 3'd0, 16'd0,   16'd100, 3'd3, 3'd3, 3'd3, 3'd3}, // R8
    {1'b0, 3'd0, 16'd200, 16'd100, 3'd3, 3'd3, 3'd3, 3'd3},
    {1'b0, 3'd4, 16'd6,   16'd100, 3'd3, 3'd3, 3'd3, 3'd3},
    {1'b1, 3'd0, 16'd0,   16'd200, 3'd3, 3'd3, 3'd3, 3'd3}, // R6
    {1'b1, 3'd0, 16'd0,   16'd200, 3'd3, 3'd3, 3'd3, 3'd6}, // R6
    {1'b0, 3'd0, 16'd300, 16'd200, 3'd3, 3'd3, 3'd3, 3'd6},
    {1'b1, 3'd0, 16'd0,   16'd300, 3'd3, 3'd3, 3'd3, 3'd6}, // R4
    {1'b0, 3'd0, 16'd301, 16'd300, 3'd3, 3'd3, 3'd3, 3'd6},
    {1'b1, 3'd0, 16'd0,   16'd301, 3'd3, 3'd3, 3'd3, 3'd6}, // R4
    {1'b0, 3'd2, 16'd7,   16'd301, 3'd3, 3'd3, 3'd3, 3'd6},
    {1'b0, 3'd3, 16'd9,   16'd301, 3'd3, 3'd3, 3'd3, 3'd6},
    {1'b1, 3'd0, 16'd0,   16'd301, 3'd3, 3'd3, 3'd3, 3'd6}, // R10
    {1'b0, 3'd1, 16'd0,   16'd301, 3'd3, 3'd3, 3'd3, 3'd6},
    {1'b0, 3'd0, 16'd400, 16'd301, 3'd3, 3'd3, 3'd3, 3'd6},
    {1'b1, 3'd0, 16'd0,   16'd400, 3'd3, 3'd3, 3'd3, 3'd6}, // R6
    {1'b1, 3'd0, 16'd0,   16'd400, 3'd0, 3'd0, 3'd0, 3'd0}, // R6
    {1'b0, 3'd0, 16'd500, 16'd400, 3'd0, 3'd0, 3'd0, 3'd0},
    {1'b0, 3'd1, 16'd1,   16'd400, 3'd0, 3'd0, 3'd0, 3'd0},
    {1'b1, 3'd0, 16'd0,   16'd500, 3'd0, 3'd0, 3'd0, 3'd0}, // R6
    {1'b0, 3'd7, 16'd5,   16'd500, 3'd0, 3'd0, 3'd0, 3'd0},
    {1'b1, 3'd0, 16'd0,   16'd500, 3'd5, 3'd1, 3'd1, 3'd1}  // R13
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] sel, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_frame();
    @(negedge clk);
    frame_valid = 1'b1;
    repeat (4) @(negedge clk);
    frame_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(TCK * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired R1..all");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int   nf = 0;
    int   tag_exp = 0;
    logic pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 exposure", 32'(live_exp), 32'd0);
    check("R12 gains", 32'(live_gain), 32'(12'o1111));
    check("R12 frame_idx", 32'(frame_idx), 32'd0);
    check("R12 exp_tag", 32'(exp_tag), 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][47]) begin
        do_frame();
        if (pend) tag_exp = nf + 2;
        pend = 1'b0;
        nf++;
        check("R3 frame_idx", 32'(frame_idx), 32'(nf));
        check("R3 exp_tag", 32'(exp_tag), 32'(tag_exp));
      end else begin
        do_write(VEC[i][46:44], VEC[i][43:28]);
        if (VEC[i][46:44] == 3'd0) pend = 1'b1;
      end
      check($sformatf("R1/R4/R5/R6/R9 exposure step %0d", i), 32'(live_exp), 32'(VEC[i][27:12]));
      check($sformatf("R5/R6/R7/R8/R10/R13 gains step %0d", i), 32'(live_gain), 32'(VEC[i][11:0]));
    end

    // R11: write in the frame-start cycle belongs to the new frame; R2: no retrigger while high
    @(negedge clk);
    frame_valid = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 16'd700;
    @(negedge clk);
    wr_en = 1'b0;
    check("R11 exposure after start", 32'(live_exp), 32'd500);
    repeat (5) @(negedge clk);
    check("R2 single start while high", 32'(frame_idx), 32'(nf + 1));
    frame_valid = 1'b0;
    repeat (3) @(negedge clk);
    nf++;
    do_frame();
    check("R11 exposure next start", 32'(live_exp), 32'd700);
    check("R3 tag after R11", 32'(exp_tag), 32'(nf + 2));
    nf++;
    check("R3 frame_idx final", 32'(frame_idx), 32'(nf));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule